// File: doc/BRIEF.md
# Event-Timing Entropy Seed Harvester

This block assembles a wide random seed on a chip that has no real-time clock. A small counter runs from power-up on every clock and is never cleared. When reset is released, its low bits become the first seed bits. Later seed bits come from the spacing of human input, such as key presses or joystick moves. Each rising edge on the raw event line is synchronised and treated as one event. The block measures the time since the previous accepted event in microsecond ticks, folds that count modulo 100, and shifts the low bits of the result into the seed.

Events that arrive too soon after the previous accepted one are discarded. This stops contact bounce from adding bits. Once at least 64 bits have been gathered, the seed is frozen and a ready flag is raised. The consumer reads the seed and then pulses the acknowledge input. Harvesting then starts again from an empty seed while both counters keep running.

Top module: `seed_harvester`

## Requirements
- R1: A boot counter, BOOT_BITS wide (6 by default), is never reset. It advances by one on every clock edge, both during reset and after it, and wraps modulo 2^BOOT_BITS.
- R2: While reset is high, the seed reads zero and ready is low. On the first clock edge with reset low, the boot counter value is shifted into the seed. That value becomes seed bits [BOOT_BITS-1:0] and all higher bits stay zero. This counts as BOOT_BITS collected bits.
- R3: The event line passes through two synchroniser flops, and only a 0-to-1 transition forms an event. A line that goes high before clock edge k is acted on at edge k+2. A line held high for many cycles gives one event.
- R4: A tick occurs every CLK_PER_US clock cycles. The interval is the number of ticks counted since the last accepted event, or since the last cycle of reset. Both the tick phase and the interval restart at each accepted event.
- R5: An accepted event takes the interval modulo MOD_BASE (100) and keeps the low BITS_PER_EVT (6) bits of the result. It shifts these into the seed: new seed = (old seed << 6) | bits, truncated to 64 bits.
- R6: An event is accepted only when the interval is at least HOLDOFF_US ticks; an interval exactly equal to it is accepted. A rejected event leaves the seed, the count and the interval timer unchanged.
- R7: Ready rises on the edge where the collected count first reaches SEED_W (64) or more. While ready is high, events are ignored and the seed does not change.
- R8: Ready stays high until seed_ack is sampled high. On that edge, the seed and the count clear, and the next events build a new seed with no boot bits. The interval timer keeps running through the acknowledge.
- R9: seed_ack sampled while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the boot counter ignores it |
| evt_raw | input | 1 | Asynchronous event line (key or joystick) |
| seed_ack | input | 1 | Consumer has taken the seed; clears it when ready is high |
| seed_value | output | SEED_W | Accumulated seed, newest bits at the LSB end |
| seed_ready | output | 1 | Seed holds at least SEED_W harvested bits |

## Verification
The bench builds the block with CLK_PER_US = 4 and HOLDOFF_US = 3. With these values the holdoff boundary falls at 12 cycles after an accepted event, so events one cycle inside and exactly at the limit are easy to place. An interval longer than 100 ticks takes about 500 cycles, which is enough to show the modulo-100 fold. The boot counter starts from an unknown power-up value. The bench therefore learns it from the first boot sample and predicts the second boot sample from the number of clock edges between the two reset releases.

// File: rtl/seed_pkg.sv
package seed_pkg;

    // Bits needed to hold the values 0 .. n-1, never less than one.
    function automatic int unsigned bits_for(input int unsigned n);
        if (n <= 1) return 1;
        return $clog2(n);
    endfunction

endpackage

// File: rtl/seed_free_ctr.sv
module seed_free_ctr #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    output logic [WIDTH-1:0] count
);
    // Deliberately no reset: the value at reset release depends on how
    // long the chip sat in reset, which is the entropy being harvested.
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } free_t;

    free_t q, d;

    always_comb begin
        d     = q;
        d.cnt = q.cnt + WIDTH'(1);
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign count = q.cnt;
endmodule

// File: rtl/seed_evt_sync.sv
module seed_evt_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic rise
);
    localparam int unsigned PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.pipe = {q.pipe[PIPE_W-2:0], raw};
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // Last synchronised stage high, one-cycle-older copy low.
    assign rise = q.pipe[SYNC_STAGES-1] & ~q.pipe[SYNC_STAGES];
endmodule

// File: rtl/seed_tick_timer.sv
module seed_tick_timer
    import seed_pkg::*;
#(
    parameter int unsigned CLK_PER_US   = 100,
    parameter int unsigned MOD_BASE     = 100,
    parameter int unsigned HOLDOFF_US   = 2000,
    parameter int unsigned BITS_PER_EVT = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    output logic [BITS_PER_EVT-1:0] evt_bits,
    output logic                    hold_ok
);
    localparam int unsigned RES_W  = bits_for(MOD_BASE);
    localparam int unsigned HOLD_W = bits_for(HOLDOFF_US + 1);
    localparam int unsigned PRE_W  = bits_for(CLK_PER_US);

    logic tick;

    // Microsecond prescaler; a divide of one needs no counter at all.
    if (CLK_PER_US > 1) begin : g_div
        logic [PRE_W-1:0] pre_q, pre_d;
        logic             at_end;

        assign at_end = (pre_q == PRE_W'(CLK_PER_US - 1));

        always_comb begin
            pre_d = pre_q + PRE_W'(1);
            if (restart || at_end) pre_d = '0;
        end

        always_ff @(posedge clk) begin
            if (rst) pre_q <= '0;
            else     pre_q <= pre_d;
        end

        assign tick = at_end;
    end else begin : g_nodiv
        assign tick = 1'b1;
    end

    typedef struct packed {
        logic [RES_W-1:0]  res;   // interval ticks, kept modulo MOD_BASE
        logic [HOLD_W-1:0] hold;  // interval ticks, saturating at HOLDOFF_US
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.res  = '0;
            d.hold = '0;
        end else if (tick) begin
            if (q.res == RES_W'(MOD_BASE - 1)) d.res = '0;
            else                               d.res = q.res + RES_W'(1);
            if (q.hold != HOLD_W'(HOLDOFF_US)) d.hold = q.hold + HOLD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign evt_bits = q.res[BITS_PER_EVT-1:0];
    assign hold_ok  = (q.hold == HOLD_W'(HOLDOFF_US));
endmodule

// File: rtl/seed_accum.sv
module seed_accum
    import seed_pkg::*;
#(
    parameter int unsigned SEED_W       = 64,
    parameter int unsigned BITS_PER_EVT = 6,
    parameter int unsigned BOOT_BITS    = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [BOOT_BITS-1:0]    boot_src,
    input  logic                    accept,
    input  logic [BITS_PER_EVT-1:0] evt_bits,
    input  logic                    ack,
    output logic [SEED_W-1:0]       seed,
    output logic                    ready,
    output logic                    boot_pend
);
    localparam int unsigned CNT_W = bits_for(SEED_W + BITS_PER_EVT + BOOT_BITS + 1);

    typedef struct packed {
        logic [SEED_W-1:0] seed;
        logic [CNT_W-1:0]  cnt;
        logic              ready;
        logic              boot;
    } acc_t;

    acc_t q, d;

    always_comb begin
        d = q;
        if (q.boot) begin
            d.seed = {q.seed[SEED_W-BOOT_BITS-1:0], boot_src};
            d.cnt  = q.cnt + CNT_W'(BOOT_BITS);
            d.boot = 1'b0;
        end else if (q.ready) begin
            if (ack) begin
                d.seed  = '0;
                d.cnt   = '0;
                d.ready = 1'b0;
            end
        end else if (accept) begin
            d.seed = {q.seed[SEED_W-BITS_PER_EVT-1:0], evt_bits};
            d.cnt  = q.cnt + CNT_W'(BITS_PER_EVT);
        end
        if (!q.ready && (d.cnt >= CNT_W'(SEED_W))) d.ready = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{seed: '0, cnt: '0, ready: 1'b0, boot: 1'b1};
        else     q <= d;
    end

    assign seed      = q.seed;
    assign ready     = q.ready;
    assign boot_pend = q.boot;
endmodule

// File: rtl/seed_harvester.sv
module seed_harvester #(
    parameter int unsigned CLK_PER_US   = 100,
    parameter int unsigned HOLDOFF_US   = 2000,
    parameter int unsigned MOD_BASE     = 100,
    parameter int unsigned BITS_PER_EVT = 6,
    parameter int unsigned BOOT_BITS    = 6,
    parameter int unsigned SEED_W       = 64,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_raw,
    input  logic              seed_ack,
    output logic [SEED_W-1:0] seed_value,
    output logic              seed_ready
);
    logic [BOOT_BITS-1:0]    free_val;
    logic                    rise;
    logic                    hold_ok;
    logic [BITS_PER_EVT-1:0] evt_bits;
    logic                    boot_pend;
    logic                    accept;

    seed_free_ctr #(.WIDTH(BOOT_BITS)) u_free (
        .clk   (clk),
        .count (free_val)
    );

    seed_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (evt_raw),
        .rise (rise)
    );

    // An edge counts only outside the holdoff and while a seed is open.
    assign accept = rise & hold_ok & ~seed_ready & ~boot_pend;

    seed_tick_timer #(
        .CLK_PER_US   (CLK_PER_US),
        .MOD_BASE     (MOD_BASE),
        .HOLDOFF_US   (HOLDOFF_US),
        .BITS_PER_EVT (BITS_PER_EVT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (accept),
        .evt_bits (evt_bits),
        .hold_ok  (hold_ok)
    );

    seed_accum #(
        .SEED_W       (SEED_W),
        .BITS_PER_EVT (BITS_PER_EVT),
        .BOOT_BITS    (BOOT_BITS)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .boot_src  (free_val),
        .accept    (accept),
        .evt_bits  (evt_bits),
        .ack       (seed_ack),
        .seed      (seed_value),
        .ready     (seed_ready),
        .boot_pend (boot_pend)
    );
endmodule

// File: rtl/seed_harvester_chk.sv
module seed_harvester_chk
    import seed_pkg::*;
#(
    parameter int unsigned CLK_PER_US   = 100,
    parameter int unsigned HOLDOFF_US   = 2000,
    parameter int unsigned BITS_PER_EVT = 6,
    parameter int unsigned BOOT_BITS    = 6,
    parameter int unsigned SEED_W       = 64
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    evt_raw,
    input logic                    seed_ack,
    input logic [SEED_W-1:0]       seed_value,
    input logic                    seed_ready,
    input logic                    accept,
    input logic [BOOT_BITS-1:0]    free_val,
    input logic [BITS_PER_EVT-1:0] evt_bits
);
    localparam int unsigned GAP_LIM = HOLDOFF_US * CLK_PER_US;
    localparam int unsigned GAP_W   = bits_for(GAP_LIM + 1);

    logic [GAP_W-1:0] gap_q;
    logic [1:0]       since_rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q       <= '0;
            since_rst_q <= '0;
        end else begin
            if (accept)                        gap_q <= '0;
            else if (gap_q != GAP_W'(GAP_LIM)) gap_q <= gap_q + GAP_W'(1);
            if (since_rst_q != 2'd3)           since_rst_q <= since_rst_q + 2'd1;
        end
    end

    p_free_step_r1: assert property (@(posedge clk) disable iff (rst)
        free_val == BOOT_BITS'($past(free_val) + 1'b1));

    p_boot_sample_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (seed_value[BOOT_BITS-1:0] == $past(free_val))
                       && (seed_value[SEED_W-1:BOOT_BITS] == '0) && !seed_ready);

    p_edge_only_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && since_rst_q == 2'd3) |-> ($past(evt_raw, 2) && !$past(evt_raw, 3)));

    p_holdoff_gap_r6: assert property (@(posedge clk) disable iff (rst)
        accept |-> (gap_q >= GAP_W'(GAP_LIM)));

    p_shift_in_r5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (seed_value[BITS_PER_EVT-1:0] == $past(evt_bits)));

    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (seed_ready && !seed_ack) |=> (seed_ready && $stable(seed_value)));

    p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (seed_ready && seed_ack) |=> (!seed_ready && seed_value == '0));

    p_stray_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (!seed_ready && seed_ack && !accept && !$fell(rst)) |=> $stable(seed_value));
endmodule

bind seed_harvester seed_harvester_chk #(
    .CLK_PER_US   (CLK_PER_US),
    .HOLDOFF_US   (HOLDOFF_US),
    .BITS_PER_EVT (BITS_PER_EVT),
    .BOOT_BITS    (BOOT_BITS),
    .SEED_W       (SEED_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_raw    (evt_raw),
    .seed_ack   (seed_ack),
    .seed_value (seed_value),
    .seed_ready (seed_ready),
    .accept     (accept),
    .free_val   (free_val),
    .evt_bits   (evt_bits)
);

// File: tb/seed_harvester_test.sv
module seed_harvester_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int HOLD       = 3;
    localparam int MODV       = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_raw = 1'b0;
    logic        seed_ack = 1'b0;
    logic [63:0] seed_value;
    logic        seed_ready;

    seed_harvester #(
        .CLK_PER_US (DIV),
        .HOLDOFF_US (HOLD)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .evt_raw    (evt_raw),
        .seed_ack   (seed_ack),
        .seed_value (seed_value),
        .seed_ready (seed_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic [63:0] exp_q[$];
    logic [63:0] m_seed = '0;
    int          m_cnt  = 0;
    bit          m_ready = 1'b0;
    int          t0 = 0;
    int          boot_c0 = 0;
    int          boot_v0 = 0;

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Scoreboard monitor: each new ready pops the next predicted seed.
    bit rdy_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            rdy_prev = 1'b0;
        end else begin
            if (seed_ready && !rdy_prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 ready with no seed predicted", seed_value, '0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk(seed_value == e, "R5 R7 seed at ready", seed_value, e);
                end
            end
            rdy_prev = seed_ready;
        end
    end

    // Driver: raise the line, predict the outcome, check the seed.
    task automatic fire(input int low_c, input int high_c, input string what);
        int a;
        int ticks;
        repeat (low_c) @(negedge clk);
        a     = cyc + 2;
        ticks = (a - t0 - 1) / DIV;
        evt_raw = 1'b1;
        if (ticks >= HOLD && !m_ready) begin
            m_seed = {m_seed[57:0], 6'((ticks % MODV) & 63)};
            m_cnt += 6;
            t0 = a;
            if (m_cnt >= 64) begin
                m_ready = 1'b1;
                exp_q.push_back(m_seed);
            end
        end
        repeat (high_c) @(negedge clk);
        evt_raw = 1'b0;
        chk(seed_value == m_seed, what, seed_value, m_seed);
        chk(seed_ready == m_ready, {what, " ready"}, 64'(seed_ready), 64'(m_ready));
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        seed_ack = 1'b1;
        @(negedge clk);
        seed_ack = 1'b0;
        if (m_ready) begin
            m_seed  = '0;
            m_cnt   = 0;
            m_ready = 1'b0;
        end
    endtask

    task automatic release_reset();
        rst = 1'b0;
        t0  = cyc - 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        chk(seed_value == '0, "R2 seed zero in reset", seed_value, '0);
        chk(seed_ready == 1'b0, "R2 ready low in reset", 64'(seed_ready), 0);

        boot_c0 = cyc;
        release_reset();
        boot_v0 = int'(seed_value[5:0]);
        chk(seed_value[63:6] == '0, "R2 boot sample upper bits", seed_value, 64'(boot_v0));
        chk(seed_ready == 1'b0, "R2 ready low after boot", 64'(seed_ready), 0);
        m_seed = 64'(boot_v0);
        m_cnt  = 6;

        // First seed: boot bits plus ten events.
        fire(20, 3, "R5 first interval");
        fire(37, 3, "R4 second interval");
        fire(1, 3, "R6 bounce rejected");
        fire(5, 3, "R6 one tick short rejected");
        fire(30, 3, "R4 interval after rejects");
        fire(10, 3, "R6 exactly at holdoff");
        pulse_ack();
        chk(seed_value == m_seed, "R9 stray ack no effect", seed_value, m_seed);
        chk(seed_ready == 1'b0, "R9 stray ack ready", 64'(seed_ready), 0);
        fire(500, 3, "R5 modulo 100 fold");
        fire(44, 25, "R3 long high one event");
        fire(18, 3, "R3 after long high");
        fire(64, 3, "R5 interval");
        fire(27, 3, "R7 60 bits not ready");
        fire(52, 3, "R7 ready at 66 bits");

        repeat (20) @(negedge clk);
        chk(seed_ready == 1'b1, "R8 ready held", 64'(seed_ready), 1);
        fire(25, 3, "R7 event ignored while ready");

        pulse_ack();
        chk(seed_value == '0, "R8 ack clears seed", seed_value, '0);
        chk(seed_ready == 1'b0, "R8 ack clears ready", 64'(seed_ready), 0);

        // Second seed: no boot bits, eleven events.
        for (int i = 0; i < 11; i++) begin
            fire(15 + 7 * i, 3, "R8 harvest after ack");
            if (i == 9)
                chk(seed_ready == 1'b0, "R7 ready low at 60 bits", 64'(seed_ready), 0);
        end
        repeat (3) @(negedge clk);
        chk(seed_ready == 1'b1, "R7 second seed ready", 64'(seed_ready), 1);

        // Second reset: boot counter kept running.
        rst = 1'b1;
        exp_q.delete();
        repeat (13) @(negedge clk);
        chk(seed_value == '0, "R2 seed cleared by reset", seed_value, '0);
        begin
            int c1;
            logic [5:0] ev;
            c1 = cyc;
            ev = 6'((boot_v0 + (c1 - boot_c0)) & 63);
            release_reset();
            chk(seed_value == 64'(ev), "R1 boot counter across reset", seed_value, 64'(ev));
            m_seed  = 64'(ev);
            m_cnt   = 6;
            m_ready = 1'b0;
        end
        fire(33, 3, "R4 interval measured from reset");
        chk(exp_q.size() == 0, "R7 all seeds delivered", 64'(exp_q.size()), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule